// File: doc/BRIEF.md
# Compare-Match System Timer with Posted Register Access

This peripheral provides a continuously running up-counter for timekeeping and one compare channel for raising a timed interrupt. The counter advances by one on every cycle in which the tick-enable input is high and counting is switched on. It wraps from all ones back to zero. A host on a simple synchronous register bus sets the compare value, reloads the counter, clears event flags and masks the interrupt.

Accesses that touch the counter domain are posted rather than immediate. Software does not read the live counter directly. It first requests a snapshot and then reads a latched copy. Reloads of the counter and updates of the compare value also complete some time after the bus write. Each of the three posted operations has its own busy flag in an access-status register. The flag is set from the write until the operation completes, a fixed number of tick-enabled cycles later. It clears in the same cycle that the effect becomes visible. Software polls these flags before it trusts a snapshot or starts the next update.

The interrupt output is a level. It stays high while the compare event flag is set and the interrupt is enabled, and it drops when software clears the flag.

Top module: `match_timer`

## Requirements
- R1: After synchronous reset the snapshot register reads 0, the compare register reads all ones, and the event flags, interrupt-enable, control and access-status registers read 0. The irq output is low.
- R2: Control bit 0 switches counting on. While it is 1, the live count rises by one on each tick-enabled cycle and wraps from all ones to 0. While it is 0 and no reload is pending, the count holds.
- R3: Writing the control register (offset 0x20) with bit 1 set requests a snapshot and sets access-status (offset 0x24) bit 5. On the third tick-enabled edge after the request, the counter register (offset 0x10) takes the live count held just before that edge, and bit 5 clears on that same edge.
- R4: A write to offset 0x10 sets access-status bit 4. On the third tick-enabled edge after the write, the live counter is loaded with the written value, and bit 4 clears on that same edge.
- R5: A write to offset 0x00 sets access-status bit 0. The comparator and reads of offset 0x00 keep the old compare value until the third tick-enabled edge after the write. On that edge the new value takes effect and bit 0 clears.
- R6: When counting is on and the live count equals the active compare value, status (offset 0x14) bit 0 is set at the next edge. It stays set until software clears it.
- R7: Writing status with bit 0 set clears the event flag. Writing it with bit 0 clear leaves the flag unchanged. Status bits 3:1 always read 0.
- R8: irq is high exactly while status bit 0 and interrupt-enable (offset 0x1C) bit 0 are both 1. Writing 0 to enable bit 0 masks irq, and writing 1 unmasks a flag that is still pending.
- R9: Posted operations advance only on cycles with tick_en high. While tick_en stays low, a busy flag stays set and nothing completes.
- R10: A second write to the same posted register while it is busy restarts the three-tick latency, and only the latest value takes effect.
- R11: Reads of offsets that hold no register return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Counter tick qualifier |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that bus_we, bus_addr and bus_wdata are known and stable around each rising edge, and that reset is held for at least one edge at start-up. The counter-hold property also assumes that the only ways to change the count are ticking while enabled and a completed reload. The stimulus changes every input only on the falling clock edge and issues at most one bus access per cycle. It holds tick_en high except during the window that tests tick gating. It chooses counter and compare values so that each expected snapshot and event edge can be computed from the cycle at which each write was issued.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Byte offsets of the register file
    typedef enum logic [7:0] {
        REG_CMP   = 8'h00,
        REG_CNT   = 8'h10,
        REG_EVT   = 8'h14,
        REG_IEN   = 8'h1C,
        REG_CTL   = 8'h20,
        REG_BUSY  = 8'h24
    } reg_off_e;

    localparam int CTL_RUN_BIT  = 0;
    localparam int CTL_SNAP_BIT = 1;
    localparam int EVT_BITS     = 4;

    // Busy flags of the posted operations
    typedef struct packed {
        logic snap;
        logic cnt_wr;
        logic cmp_wr;
    } busy_t;

    // Place the busy flags at their access-status bit positions (5, 4, 0)
    function automatic logic [7:0] busy_pack(busy_t b);
        return {2'b00, b.snap, b.cnt_wr, 3'b000, b.cmp_wr};
    endfunction

endpackage

// File: rtl/tmr_posted.sv
// Tracks one posted operation: completes LAT tick-enabled edges after request.
module tmr_posted #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] left_q;

    assign busy = (left_q != '0);
    assign done = tick && !req && (left_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (req) begin
            left_q <= CW'(LAT);
        end else if (tick && busy) begin
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/tmr_counter.sv
// Free-running counter with reload and equality compare.
module tmr_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         run,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] count,
    output logic         hit
);
    assign hit = run && (count == cmp_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick && run) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int POST_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [7:0]       bus_addr,
    input  logic             bus_we,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             irq
);
    localparam int DW = 32;
    localparam int NOPS = 3;

    // Write decode
    logic wr_cmp, wr_cnt, wr_evt, wr_ien, wr_ctl;
    assign wr_cmp = bus_we && (bus_addr == REG_CMP);
    assign wr_cnt = bus_we && (bus_addr == REG_CNT);
    assign wr_evt = bus_we && (bus_addr == REG_EVT);
    assign wr_ien = bus_we && (bus_addr == REG_IEN);
    assign wr_ctl = bus_we && (bus_addr == REG_CTL);

    // Posted operations: index 0 compare write, 1 counter write, 2 snapshot
    logic [NOPS-1:0] op_req, op_busy, op_done;
    assign op_req[0] = wr_cmp;
    assign op_req[1] = wr_cnt;
    assign op_req[2] = wr_ctl && bus_wdata[CTL_SNAP_BIT];

    for (genvar g = 0; g < NOPS; g++) begin : g_post
        tmr_posted #(.LAT(POST_LAT)) u_post (
            .clk  (clk),
            .rst  (rst),
            .tick (tick_en),
            .req  (op_req[g]),
            .busy (op_busy[g]),
            .done (op_done[g])
        );
    end

    logic mw_busy, cw_busy;
    assign mw_busy = op_busy[0];
    assign cw_busy = op_busy[1];

    busy_t busy_v;
    assign busy_v = '{snap: op_busy[2], cnt_wr: op_busy[1], cmp_wr: op_busy[0]};

    // Architectural state
    logic [CNT_W-1:0]    cmp_q, cmp_shadow, cnt_shadow, snap_q;
    logic                stat_q, run_q;
    logic [EVT_BITS-1:0] ien_q;
    logic [CNT_W-1:0]    count;
    logic                hit;

    tmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .run      (run_q),
        .load     (op_done[1]),
        .load_val (cnt_shadow),
        .cmp_val  (cmp_q),
        .count    (count),
        .hit      (hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q      <= '1;
            cmp_shadow <= '1;
            cnt_shadow <= '0;
            snap_q     <= '0;
            stat_q     <= 1'b0;
            run_q      <= 1'b0;
            ien_q      <= '0;
        end else begin
            if (wr_cmp)     cmp_shadow <= bus_wdata[CNT_W-1:0];
            if (op_done[0]) cmp_q      <= cmp_shadow;
            if (wr_cnt)     cnt_shadow <= bus_wdata[CNT_W-1:0];
            if (op_done[2]) snap_q     <= count;
            if (wr_ctl)     run_q      <= bus_wdata[CTL_RUN_BIT];
            if (wr_ien)     ien_q      <= bus_wdata[EVT_BITS-1:0];
            if (hit)
                stat_q <= 1'b1;
            else if (wr_evt && bus_wdata[0])
                stat_q <= 1'b0;
        end
    end

    logic [EVT_BITS-1:0] evt_v;
    assign evt_v = {{(EVT_BITS-1){1'b0}}, stat_q};
    assign irq   = |(evt_v & ien_q);

    // Read decode
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CMP:  bus_rdata = DW'(cmp_q);
            REG_CNT:  bus_rdata = DW'(snap_q);
            REG_EVT:  bus_rdata = DW'(evt_v);
            REG_IEN:  bus_rdata = DW'(ien_q);
            REG_CTL:  bus_rdata = DW'(run_q);
            REG_BUSY: bus_rdata = DW'(busy_pack(busy_v));
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         bus_we,
    input logic [7:0]   bus_addr,
    input logic [31:0]  bus_wdata,
    input logic [31:0]  bus_rdata,
    input logic         irq,
    input logic [W-1:0] count,
    input logic [W-1:0] cmp_q,
    input logic         stat_q,
    input logic         run_q,
    input logic         mw_busy,
    input logic         cw_busy
);
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cw_busy) |=> $stable(count));

    assert_cnt_req_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_CNT) |=> cw_busy);

    assert_cmp_req_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_CMP) |=> mw_busy);

    assert_cmp_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !mw_busy |=> $stable(cmp_q));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !(bus_we && bus_addr == REG_EVT && bus_wdata[0])) |=> stat_q);

    assert_resv_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_EVT) |-> (bus_rdata[3:1] == 3'b000));

    assert_mask_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_IEN && !bus_wdata[0]) |=> !irq);
endmodule

bind match_timer match_timer_chk #(.W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .count     (count),
    .cmp_q     (cmp_q),
    .stat_q    (stat_q),
    .run_q     (run_q),
    .mw_busy   (mw_busy),
    .cw_busy   (cw_busy)
);

// File: tb/tb_match_timer.sv
module tb_match_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        irq;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    match_timer dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [31:0] exp;
        bit          is_irq;
        string       tag;
    } item_t;

    item_t sb[$];

    // Each task occupies one cycle: drive at the falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        it.addr = a; it.exp = e; it.is_irq = 1'b0; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we = 1'b0;
        it.addr = 8'h00; it.exp = {31'b0, e}; it.is_irq = 1'b1; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic set_tick(input logic v);
        @(negedge clk);
        bus_we = 1'b0; tick_en = v;
    endtask

    // Monitor: compares 3 ns after each falling edge
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            @(negedge clk);
            #3;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                act = it.is_irq ? {31'b0, irq} : bus_rdata;
                vectors++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: %s addr %h actual %h expected %h",
                             it.tag, it.is_irq ? "irq" : "read", it.addr, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h10, 32'h0, "R1");
        rd(8'h00, 32'hFFFF_FFFF, "R1");
        rd(8'h14, 32'h0, "R1");
        rd(8'h1C, 32'h0, "R1");
        rd(8'h20, 32'h0, "R1");
        rd(8'h24, 32'h0, "R1");
        chk_irq(1'b0, "R1");

        // R4 counter reload with counting off, then R3 snapshot
        wr(8'h10, 32'h100);
        repeat (3) rd(8'h24, 32'h10, "R4");
        rd(8'h24, 32'h0, "R4");
        wr(8'h20, 32'h2);
        repeat (3) rd(8'h24, 32'h20, "R3");
        rd(8'h10, 32'h100, "R3");

        // R2 running count, snapshots of the live value
        wr(8'h20, 32'h3);
        repeat (3) rd(8'h24, 32'h20, "R3");
        rd(8'h10, 32'h102, "R2");
        wr(8'h20, 32'h3);
        repeat (3) rd(8'h24, 32'h20, "R3");
        rd(8'h10, 32'h107, "R2");

        // R2 wrap; the all-ones compare fires on the way (R6)
        wr(8'h10, 32'hFFFF_FFFE);
        repeat (3) rd(8'h24, 32'h10, "R4");
        wr(8'h20, 32'h3);
        repeat (3) rd(8'h24, 32'h20, "R3");
        rd(8'h10, 32'h1, "R2");
        rd(8'h14, 32'h1, "R6");
        chk_irq(1'b0, "R8");

        // R2 hold while counting is off
        wr(8'h20, 32'h0);
        wr(8'h10, 32'h50);
        repeat (3) rd(8'h24, 32'h10, "R4");
        idle(4);
        wr(8'h20, 32'h2);
        repeat (3) rd(8'h24, 32'h20, "R3");
        rd(8'h10, 32'h50, "R2");

        // R7 write-one-to-clear
        wr(8'h14, 32'h0);
        rd(8'h14, 32'h1, "R7");
        wr(8'h14, 32'hF);
        rd(8'h14, 32'h0, "R7");
        chk_irq(1'b0, "R7");

        // R5 posted compare write
        wr(8'h00, 32'h52);
        rd(8'h24, 32'h01, "R5");
        rd(8'h00, 32'hFFFF_FFFF, "R5");
        rd(8'h24, 32'h01, "R5");
        rd(8'h00, 32'h52, "R5");
        rd(8'h24, 32'h0, "R5");

        // R6 / R8 match event with interrupt enabled
        wr(8'h1C, 32'h1);
        wr(8'h20, 32'h1);
        repeat (3) rd(8'h14, 32'h0, "R6");
        rd(8'h14, 32'h1, "R6");
        chk_irq(1'b1, "R8");
        rd(8'h14, 32'h1, "R6");
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h0, "R7");
        chk_irq(1'b0, "R8");

        // R5 a pending compare value is not used before completion
        wr(8'h20, 32'h0);
        wr(8'h10, 32'h200);
        repeat (3) rd(8'h24, 32'h10, "R4");
        wr(8'h20, 32'h1);
        wr(8'h00, 32'h202);
        repeat (5) rd(8'h14, 32'h0, "R5");

        // R8 masking and unmasking
        wr(8'h00, 32'h210);
        wr(8'h1C, 32'h0);
        idle(9);
        rd(8'h14, 32'h1, "R6");
        chk_irq(1'b0, "R8");
        wr(8'h1C, 32'h1);
        chk_irq(1'b1, "R8");
        wr(8'h14, 32'h1);
        rd(8'h14, 32'h0, "R7");
        chk_irq(1'b0, "R8");

        // R9 no progress without ticks
        set_tick(1'b0);
        wr(8'h00, 32'hFFFF_FFFF);
        repeat (4) rd(8'h24, 32'h01, "R9");
        set_tick(1'b1);
        rd(8'h24, 32'h01, "R9");
        rd(8'h24, 32'h01, "R9");
        rd(8'h24, 32'h0, "R9");

        // R10 rewrite while busy restarts the latency
        wr(8'h00, 32'hAAAA_0000);
        rd(8'h24, 32'h01, "R10");
        wr(8'h00, 32'h1234_5678);
        rd(8'h24, 32'h01, "R10");
        rd(8'h24, 32'h01, "R10");
        rd(8'h00, 32'hFFFF_FFFF, "R10");
        rd(8'h00, 32'h1234_5678, "R10");
        rd(8'h24, 32'h0, "R10");

        // R11 unmapped offsets
        rd(8'h04, 32'h0, "R11");
        rd(8'h18, 32'h0, "R11");
        rd(8'h28, 32'h0, "R11");

        idle(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule